// File: doc/BRIEF.md
# NAND Flash Command Cycle Sequencer

This block runs one raw command transaction on an asynchronous NAND bus. Software fills a small register file with two command bytes, two 32-bit address words and an optional 32-bit data word. It then writes a control word with the start bit set. The sequencer walks a fixed chain of phases and skips any phase whose enable bit is clear. The chain is: a first command latch, a programmable run of address cycles, a second command latch, a wait for the device's ready line, and a short programmed-I/O transfer of one to four bytes in either direction.

The block drives the chip enables, the command-latch and address-latch enables, the write and read strobes, and the data bus with its output enable. Setup, strobe-low and strobe-high durations are fixed parameters counted in clock cycles. At the end of a transaction the block sets a completion flag and raises its interrupt line. A ready wait that runs too long sets a timeout flag instead of hanging. The register port and the bus pins are plain control signals. Each register write takes effect in the cycle it is presented, with no back-pressure.

Top module: `nand_cmd_seq`

Register map (index on `reg_addr`): 0 control, 1 first command byte [7:0], 2 second command byte [7:0], 3 address word low, 4 address word high, 5 data word, 6 status. Other indices read as zero.

Control word bits:
- bit 31: start.
- bit 30: first command phase.
- bit 29: address phase.
- bit 28: programmed I/O.
- bit 27: transmit.
- bit 26: receive.
- bit 25: second command phase.
- bit 16: ready wait.
- [23:20]: transfer size.
- [15:8]: one-hot chip select.
- [3:0]: address-cycle count.

Status bits:
- bit 5: done.
- bit 4: ready-wait timeout.

## Requirements
- R1: After reset, we_n and re_n are 1, cle, ale and dq_oe are 0, ce_n is all ones, irq is 0, and the control and status registers read 0.
- R2: Writing the control word with bit 31 set while idle starts a transaction. Its phases run in the order: first command (command byte A, cle high), address, second command (command byte B, cle high), ready wait, data. A phase is skipped when its enable bit (30, 29, 25, 16, or 28 together with 27 or 26) is clear.
- R3: With control [3:0] = N, the address phase issues N+1 cycles with ale high. Byte k is byte k of the 64-bit value {address high, address low}, least significant byte first. Byte indices 8 and above drive 0x00.
- R4: During a transaction ce_n equals the inverse of control bits [15:8]. Outside a transaction ce_n is all ones.
- R5: For every bus write cycle, dq_oe and the latch enables are asserted for T_SETUP cycles before we_n falls. we_n then stays low for T_LOW cycles and high for T_HIGH cycles before the data is released.
- R6: With bits 28 and 27 set, the data phase writes min(N,3)+1 bytes, where N = control [23:20]. The bytes come from the data word, byte 0 ([7:0]) first, with cle and ale low.
- R7: With bits 28 and 26 set and bit 27 clear, the data phase pulses re_n min(N,3)+1 times. The byte on dq_in during the last low cycle of pulse k is stored into data word bits [8k+7:8k].
- R8: The ready wait lasts at least T_WB cycles and then ends when rb is 1. If rb stays 0 for TIMEOUT cycles after the guard, status bit 4 is set and the data phase is skipped.
- R9: When a transaction ends, status bit 5 is set, control bit 31 reads 0 (the other control bits keep their values), and irq is 1. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: While a transaction is running, control bit 31 reads 1. Writes to the control, command, address and data registers are ignored while a transaction is running.
- R11: we_n and re_n are never low together, cle and ale are never high together, and dq_oe is 0 whenever re_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | High while any status bit is set |
| ce_n | output | NUM_CE | Active-low chip enables |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Active-low write strobe |
| re_n | output | 1 | Active-low read strobe |
| dq_out | output | 8 | Bus data out |
| dq_oe | output | 1 | Bus output enable |
| dq_in | input | 8 | Bus data in |
| rb | input | 1 | Device ready (1) / busy (0) |

## Verification
The sequencer is driven with several control-word patterns:
- A full page-read chain with every write phase enabled. This shows that the phase order and the first and second command bytes are distinguished.
- An identify-style command followed by a four-byte receive, and bare transmits of three bytes and of a clamped size. These separate the receive path from the transmit path and test the size clamp.
- A ten-cycle address run, which shows the zero fill beyond the eighth byte.

Holding rb low shows the difference between a timeout and a late release. A start written mid-transaction shows that control writes are ignored while busy. A bench bus monitor logs every latched write cycle and measures its setup and low widths.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD1 = 3'd1,
    PH_ADDR = 3'd2,
    PH_CMD2 = 3'd3,
    PH_WAIT = 3'd4,
    PH_DATA = 3'd5,
    PH_END  = 3'd6
  } phase_t;

  typedef enum logic [1:0] {
    SB_IDLE,
    SB_SETUP,
    SB_LOW,
    SB_HIGH
  } strobe_t;

  // control word bit positions
  localparam int B_GO   = 31;
  localparam int B_CMD1 = 30;
  localparam int B_ADDR = 29;
  localparam int B_PIO  = 28;
  localparam int B_TX   = 27;
  localparam int B_RX   = 26;
  localparam int B_CMD2 = 25;
  localparam int B_WAIT = 16;
  localparam int F_XSZ  = 20;
  localparam int F_CE   = 8;

  // status bit positions
  localparam int S_DONE = 5;
  localparam int S_TOUT = 4;

  // register indices
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_CMDA = 3'd1;
  localparam logic [2:0] RA_CMDB = 3'd2;
  localparam logic [2:0] RA_ADLO = 3'd3;
  localparam logic [2:0] RA_ADHI = 3'd4;
  localparam logic [2:0] RA_DATA = 3'd5;
  localparam logic [2:0] RA_STAT = 3'd6;

endpackage

// File: rtl/nand_seq_strobe.sv
module nand_seq_strobe
  import nand_seq_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_LOW   = 3,
  parameter int T_HIGH  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic low,
  output logic sample,
  output logic done
);

  localparam int TM1  = (T_SETUP > T_LOW) ? T_SETUP : T_LOW;
  localparam int TMAX = (TM1 > T_HIGH) ? TM1 : T_HIGH;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LAST_S = CW'(T_SETUP - 1);
  localparam logic [CW-1:0] LAST_L = CW'(T_LOW - 1);
  localparam logic [CW-1:0] LAST_H = CW'(T_HIGH - 1);

  strobe_t st;
  logic [CW-1:0] cnt;

  assign low    = (st == SB_LOW);
  assign sample = (st == SB_LOW)  && (cnt == LAST_L);
  assign done   = (st == SB_HIGH) && (cnt == LAST_H);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SB_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        SB_IDLE: if (start) begin
          st  <= SB_SETUP;
          cnt <= '0;
        end
        SB_SETUP: if (cnt == LAST_S) begin
          st  <= SB_LOW;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        SB_LOW: if (cnt == LAST_L) begin
          st  <= SB_HIGH;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        SB_HIGH: if (cnt == LAST_H) begin
          st  <= SB_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= SB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  input  logic        fin,
  input  logic        err_set,
  input  logic        rx_we,
  input  logic [1:0]  rx_idx,
  input  logic [7:0]  rx_byte,
  output logic [31:0] ctrl,
  output logic [7:0]  cmd_a,
  output logic [7:0]  cmd_b,
  output logic [31:0] addr_lo,
  output logic [31:0] addr_hi,
  output logic [31:0] data,
  output logic        busy,
  output logic        st_done,
  output logic [31:0] rdata,
  output logic        irq
);

  logic st_tout;
  logic cfg_wr;

  assign cfg_wr = wr && !busy;
  assign irq    = st_done | st_tout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      cmd_a   <= '0;
      cmd_b   <= '0;
      addr_lo <= '0;
      addr_hi <= '0;
      data    <= '0;
      busy    <= 1'b0;
      st_done <= 1'b0;
      st_tout <= 1'b0;
    end else begin
      if (cfg_wr) begin
        unique case (addr)
          RA_CTRL: begin
            ctrl <= wdata;
            busy <= wdata[B_GO];
          end
          RA_CMDA: cmd_a   <= wdata[7:0];
          RA_CMDB: cmd_b   <= wdata[7:0];
          RA_ADLO: addr_lo <= wdata;
          RA_ADHI: addr_hi <= wdata;
          RA_DATA: data    <= wdata;
          default: ;
        endcase
      end
      if (rx_we) data[rx_idx*8 +: 8] <= rx_byte;
      if (fin) busy <= 1'b0;
      if (wr && addr == RA_STAT) begin
        if (wdata[S_DONE]) st_done <= 1'b0;
        if (wdata[S_TOUT]) st_tout <= 1'b0;
      end
      if (fin)     st_done <= 1'b1;
      if (err_set) st_tout <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr)
      RA_CTRL: rdata = {busy, ctrl[30:0]};
      RA_CMDA: rdata = {24'h0, cmd_a};
      RA_CMDB: rdata = {24'h0, cmd_b};
      RA_ADLO: rdata = addr_lo;
      RA_ADHI: rdata = addr_hi;
      RA_DATA: rdata = data;
      RA_STAT: rdata = 32'(st_done) << S_DONE | 32'(st_tout) << S_TOUT;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int T_WB    = 4,
  parameter int TIMEOUT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  logic [31:0] ctrl,
  input  logic [7:0]  cmd_a,
  input  logic [7:0]  cmd_b,
  input  logic [31:0] addr_lo,
  input  logic [31:0] addr_hi,
  input  logic [31:0] data,
  input  logic        rb,
  input  logic [7:0]  dq_in,
  input  logic        s_done,
  input  logic        s_sample,
  output logic        start,
  output logic        cle,
  output logic        ale,
  output logic [7:0]  dq_out,
  output logic        dq_oe,
  output logic        rd_mode,
  output logic        fin,
  output logic        err_set,
  output logic        rx_we,
  output logic [1:0]  rx_idx,
  output logic [7:0]  rx_byte
);

  localparam int WW = $clog2(T_WB + TIMEOUT + 1);
  localparam logic [WW-1:0] GUARD = WW'(T_WB);
  localparam logic [WW-1:0] LIMIT = WW'(T_WB + TIMEOUT - 1);

  phase_t phase, nxt;
  logic        issued;
  logic [3:0]  bcnt;
  logic [WW-1:0] wcnt;
  logic        byte_ph, last_byte, data_en;
  logic [1:0]  xlast;
  logic [63:0] addr_all;
  logic [7:0]  abyte;

  wire unused_ctrl = ^{ctrl[B_GO], ctrl[24], ctrl[19:17], ctrl[15:4]};

  function automatic phase_t pick(input phase_t cur, input logic [31:0] c);
    phase_t p;
    p = PH_END;
    if (c[B_PIO] && (c[B_TX] || c[B_RX]) && cur < PH_DATA) p = PH_DATA;
    if (c[B_WAIT] && cur < PH_WAIT) p = PH_WAIT;
    if (c[B_CMD2] && cur < PH_CMD2) p = PH_CMD2;
    if (c[B_ADDR] && cur < PH_ADDR) p = PH_ADDR;
    if (c[B_CMD1] && cur < PH_CMD1) p = PH_CMD1;
    return p;
  endfunction

  assign nxt      = pick(phase, ctrl);
  assign data_en  = ctrl[B_PIO] && (ctrl[B_TX] || ctrl[B_RX]);
  assign rd_mode  = (phase == PH_DATA) && !ctrl[B_TX];
  assign byte_ph  = (phase == PH_CMD1) || (phase == PH_ADDR) ||
                    (phase == PH_CMD2) || (phase == PH_DATA);
  assign start    = byte_ph && !issued;
  assign xlast    = (ctrl[F_XSZ+3:F_XSZ+2] != 2'b00) ? 2'd3 : ctrl[F_XSZ+1:F_XSZ];
  assign addr_all = {addr_hi, addr_lo};
  assign abyte    = bcnt[3] ? 8'h00 : addr_all[bcnt[2:0]*8 +: 8];

  always_comb begin
    unique case (phase)
      PH_ADDR: last_byte = (bcnt == ctrl[3:0]);
      PH_DATA: last_byte = (bcnt[1:0] == xlast);
      default: last_byte = 1'b1;
    endcase
  end

  always_comb begin
    unique case (phase)
      PH_CMD1: dq_out = cmd_a;
      PH_CMD2: dq_out = cmd_b;
      PH_ADDR: dq_out = abyte;
      PH_DATA: dq_out = data[bcnt[1:0]*8 +: 8];
      default: dq_out = 8'h00;
    endcase
  end

  assign cle     = issued && ((phase == PH_CMD1) || (phase == PH_CMD2));
  assign ale     = issued && (phase == PH_ADDR);
  assign dq_oe   = issued && !rd_mode;
  assign fin     = (phase == PH_END);
  assign err_set = (phase == PH_WAIT) && (wcnt >= GUARD) && !rb && (wcnt >= LIMIT);
  assign rx_we   = s_sample && rd_mode;
  assign rx_idx  = bcnt[1:0];
  assign rx_byte = dq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      issued <= 1'b0;
      bcnt   <= '0;
      wcnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          bcnt   <= '0;
          issued <= 1'b0;
          wcnt   <= '0;
          if (busy) phase <= nxt;
        end
        PH_CMD1, PH_ADDR, PH_CMD2, PH_DATA: begin
          if (start) issued <= 1'b1;
          if (s_done) begin
            issued <= 1'b0;
            if (last_byte) begin
              phase <= nxt;
              bcnt  <= '0;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        PH_WAIT: begin
          if (wcnt < GUARD) wcnt <= wcnt + 1'b1;
          else if (rb) begin
            phase <= nxt;
            wcnt  <= '0;
          end else if (wcnt >= LIMIT) begin
            phase <= PH_END;
            wcnt  <= '0;
          end else wcnt <= wcnt + 1'b1;
        end
        PH_END:  phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // data_en is folded into pick(); kept visible for readability of the phase plan
  wire unused_den = data_en;

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int NUM_CE  = 8,
  parameter int T_SETUP = 2,
  parameter int T_LOW   = 3,
  parameter int T_HIGH  = 2,
  parameter int T_WB    = 4,
  parameter int TIMEOUT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic [NUM_CE-1:0] ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  input  logic [7:0]        dq_in,
  input  logic              rb
);

  logic [31:0] ctrl, addr_lo, addr_hi, data;
  logic [7:0]  cmd_a, cmd_b, rx_byte;
  logic [1:0]  rx_idx;
  logic busy, st_done, fin, err_set, rx_we;
  logic s_start, s_low, s_sample, s_done, rd_mode;

  nand_seq_regs u_regs (
    .clk, .rst_n,
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .fin, .err_set, .rx_we, .rx_idx, .rx_byte,
    .ctrl, .cmd_a, .cmd_b, .addr_lo, .addr_hi, .data,
    .busy, .st_done, .rdata(reg_rdata), .irq
  );

  nand_seq_fsm #(.T_WB(T_WB), .TIMEOUT(TIMEOUT)) u_fsm (
    .clk, .rst_n, .busy, .ctrl, .cmd_a, .cmd_b, .addr_lo, .addr_hi, .data,
    .rb, .dq_in, .s_done, .s_sample,
    .start(s_start), .cle, .ale, .dq_out, .dq_oe, .rd_mode,
    .fin, .err_set, .rx_we, .rx_idx, .rx_byte
  );

  nand_seq_strobe #(.T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_strobe (
    .clk, .rst_n, .start(s_start), .low(s_low), .sample(s_sample), .done(s_done)
  );

  assign we_n = ~(s_low & ~rd_mode);
  assign re_n = ~(s_low &  rd_mode);
  assign ce_n = busy ? ~ctrl[F_CE +: NUM_CE] : {NUM_CE{1'b1}};

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int NUM_CE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we_n,
  input logic              re_n,
  input logic              cle,
  input logic              ale,
  input logic              dq_oe,
  input logic [NUM_CE-1:0] ce_n,
  input logic              busy,
  input logic              fin,
  input logic              st_done
);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
  // R11
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  // R11
  rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !dq_oe);
  // R4
  idle_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (&ce_n));
  // R4
  active_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !(&ce_n));
  // R5
  we_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> dq_oe);
  // R9
  fin_done_chk: assert property (@(posedge clk) disable iff (!rst_n) fin |=> (!busy && st_done));
  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (we_n && re_n && !cle && !ale && !dq_oe));

endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.NUM_CE(NUM_CE)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(we_n), .re_n(re_n), .cle(cle), .ale(ale),
  .dq_oe(dq_oe), .ce_n(ce_n), .busy(busy), .fin(fin), .st_done(st_done)
);

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int T_SETUP = 2, T_LOW = 3, T_HIGH = 2, T_WB = 4, TIMEOUT = 64;

  localparam logic [31:0] GO = 32'h8000_0000, C1 = 32'h4000_0000, AD = 32'h2000_0000;
  localparam logic [31:0] PIO = 32'h1000_0000, TX = 32'h0800_0000, RX = 32'h0400_0000;
  localparam logic [31:0] C2 = 32'h0200_0000, WT = 32'h0001_0000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, cle, ale, we_n, re_n, dq_oe;
  logic [7:0] ce_n, dq_out, dq_in;
  logic rb = 1;

  int checks = 0, errors = 0;
  int nlog = 0, t_err = 0, x_err = 0, rcnt = 0, oe_cnt = 0, wlow = 0;
  logic [9:0] log_q [0:31];
  logic [7:0] ce_seen = 8'hFF;
  logic prev_we = 1, prev_re = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_seq #(.T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HIGH(T_HIGH),
                 .T_WB(T_WB), .TIMEOUT(TIMEOUT)) uut (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq,
    .ce_n, .cle, .ale, .we_n, .re_n, .dq_out, .dq_oe, .dq_in, .rb
  );

  assign dq_in = 8'hA0 + 8'(rcnt);

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_we && !we_n) begin
        if (oe_cnt != T_SETUP) t_err++;
        wlow = 0;
        ce_seen = ce_n;
      end
      if (!we_n) wlow++;
      if (!prev_we && we_n) begin
        if (wlow != T_LOW) t_err++;
        if (nlog < 32) log_q[nlog] = {cle, ale, dq_out};
        nlog++;
      end
      if (!dq_oe) oe_cnt = 0;
      else if (we_n) oe_cnt++;
      if (!prev_re && re_n) rcnt++;
      if (!we_n && !re_n) x_err++;
      if (cle && ale) x_err++;
      if (!re_n && dq_oe) x_err++;
      prev_we = we_n;
      prev_re = re_n;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog expired");
    errors++;
    finish_run();
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    int i;
    s = 0;
    for (i = 0; i < 5000; i++) begin
      rd(3'd6, s);
      if (s[5]) break;
    end
    check(s[5] == 1'b1, req, s, 32'h20);
  endtask

  task automatic log_is(input string req, input int idx, input logic [9:0] exp);
    check(nlog > idx && log_q[idx] == exp, req, (nlog > idx) ? log_q[idx] : 10'h3FF, exp);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    @(negedge clk);
    check(we_n && re_n && !cle && !ale && !dq_oe, "R1 bus idle",
          {we_n, re_n, cle, ale, dq_oe}, 5'b11000);
    check(ce_n == 8'hFF && !irq, "R1 ce_n/irq", {ce_n, irq}, {8'hFF, 1'b0});
    rd(3'd0, d); check(d == 0, "R1 control", d, 0);
    rd(3'd6, d); check(d == 0, "R1 status", d, 0);
  endtask

  task automatic test_page_read();
    logic [31:0] d;
    nlog = 0;
    wr(3'd1, 32'h00); wr(3'd2, 32'h30);
    wr(3'd3, 32'h5678_1234); wr(3'd4, 32'h0000_009A);
    wr(3'd0, GO | C1 | AD | C2 | WT | 32'h0000_0204);
    wait_done("R9 page read done");
    check(nlog == 7, "R2 page read cycle count", nlog, 7);
    log_is("R2 first command", 0, {2'b10, 8'h00});
    log_is("R3 addr byte0", 1, {2'b01, 8'h34});
    log_is("R3 addr byte1", 2, {2'b01, 8'h12});
    log_is("R3 addr byte2", 3, {2'b01, 8'h78});
    log_is("R3 addr byte3", 4, {2'b01, 8'h56});
    log_is("R3 addr byte4", 5, {2'b01, 8'h9A});
    log_is("R2 second command", 6, {2'b10, 8'h30});
    check(ce_seen == 8'hFD, "R4 chip select", ce_seen, 8'hFD);
    check(ce_n == 8'hFF, "R4 idle ce_n", ce_n, 8'hFF);
    rd(3'd0, d);
    check(d == (C1 | AD | C2 | WT | 32'h204), "R9 GO cleared", d, C1 | AD | C2 | WT | 32'h204);
    check(irq == 1'b1, "R9 irq", irq, 1);
  endtask

  task automatic test_clear();
    logic [31:0] d;
    wr(3'd6, 32'h0);
    rd(3'd6, d); check(d == 32'h20, "R9 write 0 keeps", d, 32'h20);
    wr(3'd6, 32'h20);
    rd(3'd6, d); check(d == 32'h0, "R9 W1C clears", d, 0);
    check(irq == 1'b0, "R9 irq low", irq, 0);
  endtask

  task automatic test_rx();
    logic [31:0] d, e;
    int base;
    nlog = 0; base = rcnt;
    wr(3'd1, 32'h90); wr(3'd3, 32'h0);
    wr(3'd0, GO | C1 | AD | PIO | RX | 32'h0030_0100);
    wait_done("R7 rx done");
    check(nlog == 2, "R7 write cycles before rx", nlog, 2);
    log_is("R2 id command", 0, {2'b10, 8'h90});
    log_is("R3 single addr", 1, {2'b01, 8'h00});
    check(rcnt - base == 4, "R7 re pulses", rcnt - base, 4);
    e = {8'hA3 + 8'(base), 8'hA2 + 8'(base), 8'hA1 + 8'(base), 8'hA0 + 8'(base)};
    rd(3'd5, d); check(d == e, "R7 rx data", d, e);
    check(ce_n == 8'hFF, "R4 idle after rx", ce_n, 8'hFF);
    wr(3'd6, 32'h30);
  endtask

  task automatic test_tx();
    int base;
    nlog = 0; base = rcnt;
    wr(3'd5, 32'h4433_2211);
    wr(3'd0, GO | PIO | TX | 32'h0020_0400);
    wait_done("R6 tx done");
    check(nlog == 3, "R6 tx three bytes", nlog, 3);
    log_is("R6 tx byte0", 0, {2'b00, 8'h11});
    log_is("R6 tx byte1", 1, {2'b00, 8'h22});
    log_is("R6 tx byte2", 2, {2'b00, 8'h33});
    check(rcnt == base, "R6 no read strobe", rcnt - base, 0);
    check(ce_seen == 8'hFB, "R4 chip 2", ce_seen, 8'hFB);
    wr(3'd6, 32'h30);
    nlog = 0;
    wr(3'd0, GO | PIO | TX | 32'h0090_0100);
    wait_done("R6 clamp done");
    check(nlog == 4, "R6 size clamp", nlog, 4);
    log_is("R6 clamp last", 3, {2'b00, 8'h44});
    wr(3'd6, 32'h30);
  endtask

  task automatic test_long_addr();
    nlog = 0;
    wr(3'd3, 32'h0403_0201); wr(3'd4, 32'h0807_0605);
    wr(3'd0, GO | AD | 32'h0000_0109);
    wait_done("R3 long addr done");
    check(nlog == 10, "R3 ten cycles", nlog, 10);
    log_is("R3 byte7", 7, {2'b01, 8'h08});
    log_is("R3 byte8 zero", 8, {2'b01, 8'h00});
    log_is("R3 byte9 zero", 9, {2'b01, 8'h00});
    wr(3'd6, 32'h30);
  endtask

  task automatic test_timeout();
    logic [31:0] d;
    nlog = 0; rb = 0;
    wr(3'd1, 32'h70); wr(3'd5, 32'h0000_005A);
    wr(3'd0, GO | C1 | WT | PIO | TX | 32'h0000_0100);
    wait_done("R8 timeout done");
    rd(3'd6, d); check(d == 32'h30, "R8 timeout flag", d, 32'h30);
    check(nlog == 1, "R8 data skipped", nlog, 1);
    log_is("R8 command sent", 0, {2'b10, 8'h70});
    wr(3'd6, 32'h30);
    rb = 1;
  endtask

  task automatic test_release();
    logic [31:0] d;
    nlog = 0; rb = 0;
    wr(3'd0, GO | C1 | WT | PIO | TX | 32'h0000_0100);
    repeat (30) @(negedge clk);
    rd(3'd6, d); check(d == 0, "R8 still waiting", d, 0);
    rb = 1;
    wait_done("R8 release done");
    rd(3'd6, d); check(d == 32'h20, "R8 no timeout", d, 32'h20);
    check(nlog == 2, "R8 data after ready", nlog, 2);
    log_is("R8 data byte", 1, {2'b00, 8'h5A});
    wr(3'd6, 32'h30);
  endtask

  task automatic test_busy_ignore();
    logic [31:0] d;
    nlog = 0; rb = 0;
    wr(3'd5, 32'h1122_3344);
    wr(3'd1, 32'h60);
    wr(3'd0, GO | C1 | WT | 32'h0000_0100);
    repeat (10) @(negedge clk);
    rd(3'd0, d); check(d[31] == 1'b1, "R10 busy reads GO", d, GO | C1 | WT | 32'h100);
    wr(3'd0, GO | PIO | TX | 32'h0000_0100);
    wr(3'd5, 32'hDEAD_BEEF);
    wr(3'd1, 32'hEE);
    rb = 1;
    wait_done("R10 done");
    check(nlog == 1, "R10 no restart", nlog, 1);
    log_is("R10 original command", 0, {2'b10, 8'h60});
    rd(3'd5, d); check(d == 32'h1122_3344, "R10 data kept", d, 32'h1122_3344);
    rd(3'd0, d); check(d == (C1 | WT | 32'h100), "R10 control kept", d, C1 | WT | 32'h100);
    repeat (20) @(negedge clk);
    check(nlog == 1, "R10 nothing after", nlog, 1);
    wr(3'd6, 32'h30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_page_read();
    test_clear();
    test_rx();
    test_tx();
    test_long_addr();
    test_timeout();
    test_release();
    test_busy_ignore();
    check(t_err == 0, "R5 setup/low widths", t_err, 0);
    check(x_err == 0, "R11 strobe exclusion", x_err, 0);
    finish_run();
  end

endmodule